// File: doc/BRIEF.md
# SPI Slave Port with Underrun and Overrun Detection

This block is a single-channel SPI slave. An external master drives the serial clock, the data line into the slave and an active-low select; the block drives the return data line. All three serial inputs are brought into the system clock domain through multi-flop synchronizers. Clock edges are found there by comparing consecutive samples, so the system clock must run at least four times faster than the serial clock.

Local logic talks to the port through single-cycle strobes. A transmit holding register is loaded by a write strobe and a receive holding register is emptied by a read strobe. Each register has a ready flag. An underrun flag reports a character that had to be sent while nothing was held for transmit. An overrun flag reports a received character that overwrote one nobody had read. A reset-status strobe clears both error flags.

The serial format is fixed. The clock idles low. The slave launches each bit after a rising clock edge and captures the incoming bit on the falling edge. Characters are sent most significant bit first. A character starts at the first rising clock edge seen while the select is low, so no falling select edge is needed between characters. There is no receive timeout, because the serial clock only runs while data moves.

Top module: `spi_slv_top`

## Requirements
- R1: After reset, tx_rdy_o is 1, rx_rdy_o, underrun_o and overrun_o are 0, and miso_o is 1.
- R2: A character is DATA_W bits, most significant bit first. miso_o changes after a rising SCK edge, and mosi_i is captured on the falling SCK edge.
- R3: A character begins at the first rising SCK edge while ss_ni is low. A low level is enough, and ss_ni may stay low across several characters.
- R4: Back-to-back characters separated by one bit time, with ss_ni held low, are each sent and received correctly.
- R5: A tx_wr_i strobe while tx_rdy_o is 1 stores tx_data_i and clears tx_rdy_o. A strobe while tx_rdy_o is 0 is lost and leaves the held word unchanged.
- R6: tx_rdy_o returns to 1 when a character starts and the held word moves into the shifter.
- R7: If the transmit register is empty when a character starts, underrun_o sets and miso_o stays 1 for every bit of that character.
- R8: A completed character appears on rx_data_o and sets rx_rdy_o. An rx_rd_i strobe clears rx_rdy_o.
- R9: A character that completes while rx_rdy_o is 1, with no read in the same cycle, sets overrun_o and replaces rx_data_o.
- R10: A rst_sta_i strobe clears underrun_o and overrun_o.
- R11: While ss_ni is high, miso_o is 1 and the bit count is zero. A partial character cut off by ss_ni going high is discarded, and the next character starts from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the master |
| mosi_i | input | 1 | Serial data from the master |
| ss_ni | input | 1 | Active-low slave select |
| miso_o | output | 1 | Serial data to the master |
| tx_wr_i | input | 1 | Write strobe for the transmit holding register |
| tx_data_i | input | DATA_W | Word to transmit |
| tx_rdy_o | output | 1 | Transmit holding register is empty |
| rx_rd_i | input | 1 | Read strobe that consumes the received word |
| rx_data_o | output | DATA_W | Last received word |
| rx_rdy_o | output | 1 | A received word is waiting |
| rst_sta_i | input | 1 | Clears the underrun and overrun flags |
| underrun_o | output | 1 | A character was sent with the transmit register empty |
| overrun_o | output | 1 | A received word was overwritten before it was read |

## Verification
The master model sends several characters: alternating bits, all zeros, all ones, and values with a single bit set at one end. These patterns separate a swapped bit order or an off-by-one capture edge from a correct shift. Two characters sent one bit time apart with select held low show that the character boundary comes from the bit count and not from a select edge. A character sent with nothing held, followed by one that is not read, exercises the two error paths and their clearing. A character cut short by raising select, followed by a full one, shows whether leftover bits leak into the next received word.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;
  parameter int unsigned DEF_DATA_W = 8;
  parameter int unsigned DEF_SYNC_STAGES = 2;

  typedef struct packed {
    logic rise;
    logic fall;
  } sck_edge_t;
endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
  parameter int unsigned WIDTH = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[g] <= RST_VAL;
      else if (g == 0) stage_q[g] <= d_i;
      else stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_slv_shift.sv
module spi_slv_shift
  import spi_slv_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              mosi_i,
  input  logic              ss_act_i,
  input  logic              tx_full_i,
  input  logic [DATA_W-1:0] tx_word_i,
  output logic              load_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_word_o,
  output logic              miso_o,
  output logic [CNT_W-1:0]  bit_cnt_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W-1);

  logic              sck_q;
  sck_edge_t         edge_s;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [DATA_W-1:0] tx_sh_q;
  logic [DATA_W-1:0] rx_sh_q;

  assign edge_s.rise = sck_i & ~sck_q;
  assign edge_s.fall = ~sck_i & sck_q;

  // character start: leading edge with nothing shifted yet
  assign load_o    = ss_act_i & edge_s.rise & (bit_cnt_q == '0);
  assign done_o    = ss_act_i & edge_s.fall & (bit_cnt_q == LAST);
  assign rx_word_o = {rx_sh_q[DATA_W-2:0], mosi_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q     <= 1'b0;
      bit_cnt_q <= '0;
      tx_sh_q   <= '1;
      rx_sh_q   <= '0;
    end else begin
      sck_q <= sck_i;
      if (!ss_act_i) begin
        bit_cnt_q <= '0;
        tx_sh_q   <= '1;
        rx_sh_q   <= '0;
      end else begin
        if (edge_s.rise) begin
          if (bit_cnt_q == '0) tx_sh_q <= tx_full_i ? tx_word_i : '1;
          else tx_sh_q <= {tx_sh_q[DATA_W-2:0], 1'b1};
        end
        if (edge_s.fall) begin
          rx_sh_q   <= {rx_sh_q[DATA_W-2:0], mosi_i};
          bit_cnt_q <= (bit_cnt_q == LAST) ? '0 : bit_cnt_q + 1'b1;
        end
      end
    end
  end

  assign miso_o    = tx_sh_q[DATA_W-1];
  assign bit_cnt_o = bit_cnt_q;
endmodule

// File: rtl/spi_slv_regs.sv
module spi_slv_regs
  import spi_slv_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_wr_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              load_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] rx_word_i,
  input  logic              rx_rd_i,
  input  logic              rst_sta_i,
  output logic [DATA_W-1:0] tx_word_o,
  output logic              tx_full_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_rdy_o,
  output logic              underrun_o,
  output logic              overrun_o
);
  logic [DATA_W-1:0] thr_q, rhr_q;
  logic              thr_full_q, rx_rdy_q, unre_q, ovre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q      <= '0;
      thr_full_q <= 1'b0;
    end else begin
      if (tx_wr_i && !thr_full_q) begin
        thr_q      <= tx_data_i;
        thr_full_q <= 1'b1;
      end else if (load_i) begin
        thr_full_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rhr_q    <= '0;
      rx_rdy_q <= 1'b0;
    end else if (done_i) begin
      rhr_q    <= rx_word_i;
      rx_rdy_q <= 1'b1;
    end else if (rx_rd_i) begin
      rx_rdy_q <= 1'b0;
    end
  end

  // setting wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unre_q <= 1'b0;
      ovre_q <= 1'b0;
    end else begin
      if (load_i && !thr_full_q) unre_q <= 1'b1;
      else if (rst_sta_i) unre_q <= 1'b0;
      if (done_i && rx_rdy_q && !rx_rd_i) ovre_q <= 1'b1;
      else if (rst_sta_i) ovre_q <= 1'b0;
    end
  end

  assign tx_word_o  = thr_q;
  assign tx_full_o  = thr_full_q;
  assign rx_data_o  = rhr_q;
  assign rx_rdy_o   = rx_rdy_q;
  assign underrun_o = unre_q;
  assign overrun_o  = ovre_q;
endmodule

// File: rtl/spi_slv_top.sv
module spi_slv_top
  import spi_slv_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
  localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              mosi_i,
  input  logic              ss_ni,
  output logic              miso_o,
  input  logic              tx_wr_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_rdy_o,
  input  logic              rx_rd_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_rdy_o,
  input  logic              rst_sta_i,
  output logic              underrun_o,
  output logic              overrun_o
);
  logic [2:0]        pins_sync;
  logic              sck_s, mosi_s, ss_act;
  logic              ld_req, rx_done, tx_full;
  logic [DATA_W-1:0] tx_word, rx_word;
  logic [CNT_W-1:0]  bit_cnt;

  spi_slv_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ss_ni, mosi_i, sck_i}),
    .q_o   (pins_sync)
  );

  assign sck_s  = pins_sync[0];
  assign mosi_s = pins_sync[1];
  assign ss_act = ~pins_sync[2];

  spi_slv_shift #(.DATA_W(DATA_W)) i_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sck_i    (sck_s),
    .mosi_i   (mosi_s),
    .ss_act_i (ss_act),
    .tx_full_i(tx_full),
    .tx_word_i(tx_word),
    .load_o   (ld_req),
    .done_o   (rx_done),
    .rx_word_o(rx_word),
    .miso_o   (miso_o),
    .bit_cnt_o(bit_cnt)
  );

  spi_slv_regs #(.DATA_W(DATA_W)) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tx_wr_i   (tx_wr_i),
    .tx_data_i (tx_data_i),
    .load_i    (ld_req),
    .done_i    (rx_done),
    .rx_word_i (rx_word),
    .rx_rd_i   (rx_rd_i),
    .rst_sta_i (rst_sta_i),
    .tx_word_o (tx_word),
    .tx_full_o (tx_full),
    .rx_data_o (rx_data_o),
    .rx_rdy_o  (rx_rdy_o),
    .underrun_o(underrun_o),
    .overrun_o (overrun_o)
  );

  assign tx_rdy_o = ~tx_full;
endmodule

// File: rtl/spi_slv_chk.sv
module spi_slv_chk #(
  parameter int unsigned CNT_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ss_act,
  input logic             ld_req,
  input logic             rx_done,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             miso_o,
  input logic             tx_wr_i,
  input logic             tx_rdy_o,
  input logic             rx_rd_i,
  input logic             rx_rdy_o,
  input logic             rst_sta_i,
  input logic             underrun_o,
  input logic             overrun_o
);
  AST_IDLE_MISO_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ss_act |=> miso_o); // R11

  AST_IDLE_CNT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ss_act |=> bit_cnt == '0); // R11

  AST_UNDERRUN_MISO_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(underrun_o) |-> miso_o); // R7

  AST_WRITE_FILLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_wr_i && tx_rdy_o |=> !tx_rdy_o); // R5

  AST_LOAD_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_req && !tx_wr_i |=> tx_rdy_o); // R6

  AST_RXRDY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done |=> rx_rdy_o); // R8

  AST_OVERRUN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done && rx_rdy_o && !rx_rd_i |=> overrun_o); // R9

  AST_STATUS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_sta_i && !ld_req && !rx_done |=> !underrun_o && !overrun_o); // R10
endmodule

bind spi_slv_top spi_slv_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ss_act    (ss_act),
  .ld_req    (ld_req),
  .rx_done   (rx_done),
  .bit_cnt   (bit_cnt),
  .miso_o    (miso_o),
  .tx_wr_i   (tx_wr_i),
  .tx_rdy_o  (tx_rdy_o),
  .rx_rd_i   (rx_rd_i),
  .rx_rdy_o  (rx_rdy_o),
  .rst_sta_i (rst_sta_i),
  .underrun_o(underrun_o),
  .overrun_o (overrun_o)
);

// File: tb/test_spi_slv_top.sv
module test_spi_slv_top;
  localparam int HALF = 8;          // system cycles per SCK half period
  localparam int BIT_T = 2 * HALF;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sck = 1'b0, mosi = 1'b0, ss_n = 1'b1;
  logic       tx_wr = 1'b0, rx_rd = 1'b0, rst_sta = 1'b0;
  logic [7:0] tx_data = '0;
  logic       miso, tx_rdy, rx_rdy, underrun, overrun;
  logic [7:0] rx_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];

  always #4 clk = ~clk;

  spi_slv_top i_spi_slv_top (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .mosi_i(mosi), .ss_ni(ss_n),
    .miso_o(miso), .tx_wr_i(tx_wr), .tx_data_i(tx_data), .tx_rdy_o(tx_rdy),
    .rx_rd_i(rx_rd), .rx_data_o(rx_data), .rx_rdy_o(rx_rdy),
    .rst_sta_i(rst_sta), .underrun_o(underrun), .overrun_o(overrun)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr_tx(input logic [7:0] d);
    tx_data = d; tx_wr = 1'b1; tick(1); tx_wr = 1'b0;
  endtask

  task automatic rd_rx();
    rx_rd = 1'b1; tick(1); rx_rd = 1'b0;
  endtask

  task automatic sta_clr();
    rst_sta = 1'b1; tick(1); rst_sta = 1'b0;
  endtask

  task automatic sample();
    @(negedge clk);
  endtask

  // mode: SCK idles low, master launches on rise, slave captures on fall
  task automatic xfer(input logic [7:0] mo, input logic [7:0] exp_mi,
                      input int nbits, input string req);
    logic [7:0] got = 8'hFF;
    for (int i = 7; i > 7 - nbits; i--) begin
      sck = 1'b1; mosi = mo[i];
      tick(HALF);
      got[i] = miso;
      sck = 1'b0;
      tick(HALF);
    end
    for (int i = 7; i > 7 - nbits; i--) chk({req, " miso bit"}, got[i], exp_mi[i]);
  endtask

  // scoreboard monitor: every new received word is compared with the queue head
  initial begin
    logic prev = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && rx_rdy && !prev) begin
        if (exp_q.size() == 0) chk("R8 unexpected word", rx_data, 32'hFFFF_FFFF);
        else chk("R8 rx word", rx_data, exp_q.pop_front());
      end
      prev = rx_rdy;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2); sample();
    chk("R1 tx_rdy", tx_rdy, 1); chk("R1 rx_rdy", rx_rdy, 0);
    chk("R1 underrun", underrun, 0); chk("R1 overrun", overrun, 0);
    chk("R1 miso", miso, 1);

    // R5: write fills, second write is lost
    wr_tx(8'hA5); sample(); chk("R5 tx_rdy after write", tx_rdy, 0);
    wr_tx(8'h3C); sample(); chk("R5 tx_rdy still low", tx_rdy, 0);

    // R2 R3: select low level then clock
    ss_n = 1'b0; tick(BIT_T);
    exp_q.push_back(8'h5A);
    xfer(8'h5A, 8'hA5, 8, "R2 R5");
    sample(); chk("R6 tx_rdy after start", tx_rdy, 1);
    wr_tx(8'h81);
    tick(BIT_T - 1);
    sample(); chk("R8 rx_rdy", rx_rdy, 1);
    rd_rx(); sample(); chk("R8 rx_rdy cleared", rx_rdy, 0);

    // R4: back-to-back characters, select held low
    exp_q.push_back(8'hC3);
    xfer(8'hC3, 8'h81, 8, "R4 R3");
    wr_tx(8'h00);
    tick(BIT_T - 1); rd_rx();
    exp_q.push_back(8'hFF);
    xfer(8'hFF, 8'h00, 8, "R4 zeros");
    wr_tx(8'h01);
    tick(BIT_T - 1); rd_rx();
    exp_q.push_back(8'h80);
    xfer(8'h80, 8'h01, 8, "R4 lsb only");
    tick(BIT_T); rd_rx();
    sample(); chk("R7 no underrun yet", underrun, 0);

    // R7: nothing held
    exp_q.push_back(8'h0F);
    xfer(8'h0F, 8'hFF, 8, "R7");
    sample(); chk("R7 underrun set", underrun, 1);
    tick(BIT_T); rd_rx();
    sta_clr(); sample(); chk("R10 underrun cleared", underrun, 0);

    // R9: unread word overwritten
    wr_tx(8'h22);
    exp_q.push_back(8'h11);
    xfer(8'h11, 8'h22, 8, "R9 first");
    wr_tx(8'h44);
    tick(BIT_T);
    xfer(8'h99, 8'h44, 8, "R9 second");
    tick(BIT_T); sample();
    chk("R9 overrun set", overrun, 1);
    chk("R9 data replaced", rx_data, 8'h99);
    chk("R9 rx_rdy held", rx_rdy, 1);
    sta_clr(); sample(); chk("R10 overrun cleared", overrun, 0);
    rd_rx();

    // R11: cut a character short
    wr_tx(8'hF0);
    xfer(8'h6D, 8'hF0, 3, "R11 partial");
    ss_n = 1'b1; tick(6); sample();
    chk("R11 miso high idle", miso, 1);
    chk("R11 no word", rx_rdy, 0);
    ss_n = 1'b0; tick(BIT_T);
    wr_tx(8'h66);
    exp_q.push_back(8'h77);
    xfer(8'h77, 8'h66, 8, "R11 restart");
    tick(BIT_T); sample();
    chk("R11 no underrun", underrun, 0);
    rd_rx();
    ss_n = 1'b1;
    tick(BIT_T); sample();
    chk("R8 scoreboard drained", exp_q.size(), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule